// File: doc/BRIEF.md
# Hardware Buffer Stack Manager

This block keeps a set of last-in first-out stacks of free buffer descriptors for a packet engine. Software and hardware reach it through memory-mapped accesses. A store places a buffer virtual address on the stack named by the address. A load removes the most recently stored address from the stack named by the address. The load returns a status word one cycle later. That word carries the address, the stack it came from, a hardware-buffer marker, the stack's encoded buffer size and a two-bit validity code.

Each stack serves buffers of one size. The size code for each stack comes from a configuration input, not from the caller. The size codes 0 to 7 stand for buffers of 128, 256, 512, 1024, 1664, 4096, 10368 and 16384 bytes. The block only passes the code through and never interprets it.

All stacks share one storage array that is divided into equal slices, one slice per stack. A store to a full stack is lost and raises a sticky overflow flag for that stack. A store and a load in the same cycle are handled store first, so the load can return the address that was just stored.

Top module: `bufstack_mgr`

## Requirements
- R1: An access is accepted only when address bits [28:26] equal 6. A store with any other value changes no state. A load with any other value produces no response.
- R2: Address bits [7:3] select the stack. The response carries that index in bits [52:48]. The stacks are independent of one another.
- R3: Stacks are last-in first-out. An accepted load raises `resp_valid` in the following cycle, with the response on `resp_data`.
- R4: A successful pop returns validity code 0 in bits [63:62] and the stored address in bits [41:7].
- R5: A load from an empty stack returns validity code 3 with address bits [41:7] at zero.
- R6: Every response has bit 58 (hardware buffer) at 1 and bits [57:56] (owner instance) at 0.
- R7: Response bits [61:59] hold the `cfg_size` code of the addressed stack. On a store, only data bits [41:7] are used, and every other data bit is ignored.
- R8: A store to a stack that already holds DEPTH entries is dropped. It sets that stack's bit in `stk_ovf`, and the bit stays set until reset.
- R9: When a store and a load arrive in the same cycle, the store takes effect first. This holds even when both target the same stack.
- R10: `stk_empty[i]` is 1 exactly when stack i holds no entries.
- R11: A stack index of NUM_STACKS or more is outside the block. A store to it is ignored. A load from it returns code 3 and size code 0.
- R12: After reset, all stacks are empty, no overflow flag is set and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address (region and stack fields) |
| st_data | input | 64 | Store data; bits [41:7] are the buffer address |
| ld_valid | input | 1 | Load (pop) request |
| ld_addr | input | ADDR_W | Load address (region and stack fields) |
| cfg_size | input | 3*NUM_STACKS | Size code per stack; stack i uses bits [3i+2:3i] |
| resp_valid | output | 1 | Pop response valid |
| resp_data | output | 64 | Pop response word |
| stk_empty | output | NUM_STACKS | Per-stack empty flag |
| stk_ovf | output | NUM_STACKS | Per-stack sticky overflow flag |

## Verification
The hardest case to reach is a store and a load to the same stack in the same cycle while that stack is full. The store must be dropped and flagged, and the load must still return the old top entry. The bench fills one stack to DEPTH entries with single stores, then issues a store and a load together on that stack. It checks both the returned address and the overflow flag. A second stack is filled past its depth and then drained, to confirm that the dropped address never appears.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    localparam int WORD_W    = 64;
    localparam int REGION_LO = 26;
    localparam int REGION_W  = 3;
    localparam logic [2:0] REGION_ID = 3'd6;
    localparam int STK_LO    = 3;
    localparam int STK_W     = 5;
    localparam int VA_LO     = 7;
    localparam int VA_W      = 35;
    localparam int SZ_W      = 3;

    localparam logic [1:0] CODE_OK   = 2'd0;
    localparam logic [1:0] CODE_NONE = 2'd3;
endpackage

// File: rtl/bsm_addr_dec.sv
module bsm_addr_dec
    import bsm_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int NUM_STACKS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [STK_W-1:0]  idx,
    output logic              in_range
);
    logic unused_addr;

    assign hit      = (addr[REGION_LO +: REGION_W] == REGION_ID);
    assign idx      = addr[STK_LO +: STK_W];
    assign in_range = (int'(idx) < NUM_STACKS);

    assign unused_addr = ^{addr[ADDR_W-1:REGION_LO+REGION_W],
                           addr[REGION_LO-1:STK_LO+STK_W], addr[STK_LO-1:0]};
endmodule

// File: rtl/bsm_word_fmt.sv
module bsm_word_fmt
    import bsm_pkg::*;
(
    input  logic [1:0]       code,
    input  logic [SZ_W-1:0]  size,
    input  logic [STK_W-1:0] stk,
    input  logic [VA_W-1:0]  va,
    output logic [WORD_W-1:0] word
);
    // code | size | hw-buffer | instance | rsvd | stack | rsvd | address | rsvd
    assign word = {code, size, 1'b1, 2'b00, 3'b000, stk, 6'b000000, va, 7'b0000000};
endmodule

// File: rtl/bufstack_mgr.sv
module bufstack_mgr
    import bsm_pkg::*;
#(
    parameter int NUM_STACKS = 8,
    parameter int DEPTH      = 4,
    parameter int ADDR_W     = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      st_valid,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic [63:0]               st_data,
    input  logic                      ld_valid,
    input  logic [ADDR_W-1:0]         ld_addr,
    input  logic [3*NUM_STACKS-1:0]   cfg_size,
    output logic                      resp_valid,
    output logic [63:0]               resp_data,
    output logic [NUM_STACKS-1:0]     stk_empty,
    output logic [NUM_STACKS-1:0]     stk_ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT   = NUM_STACKS * DEPTH;
    localparam int ENT_W = (ENT > 1) ? $clog2(ENT) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [ENT-1:0][VA_W-1:0]        mem;
        logic [NUM_STACKS-1:0][CNT_W-1:0] cnt;
        logic [NUM_STACKS-1:0]            ovf;
        logic                             rv;
        logic [1:0]                       rcode;
        logic [SZ_W-1:0]                  rsize;
        logic [STK_W-1:0]                 rstk;
        logic [VA_W-1:0]                  rva;
    } state_t;

    state_t s_d, s_q;

    logic             st_hit, st_in, ld_hit, ld_in;
    logic [STK_W-1:0] st_idx, ld_idx;
    logic [CNT_W-1:0] c_tmp;
    logic             unused_data;

    assign unused_data = ^{st_data[63:VA_LO+VA_W], st_data[VA_LO-1:0]};

    bsm_addr_dec #(.ADDR_W(ADDR_W), .NUM_STACKS(NUM_STACKS)) u_st_dec (
        .addr(st_addr), .hit(st_hit), .idx(st_idx), .in_range(st_in)
    );

    bsm_addr_dec #(.ADDR_W(ADDR_W), .NUM_STACKS(NUM_STACKS)) u_ld_dec (
        .addr(ld_addr), .hit(ld_hit), .idx(ld_idx), .in_range(ld_in)
    );

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        c_tmp  = '0;

        // store is applied first
        if (st_valid && st_hit && st_in) begin
            c_tmp = s_d.cnt[st_idx];
            if (c_tmp == FULL_CNT) begin
                s_d.ovf[st_idx] = 1'b1;
            end else begin
                s_d.mem[ENT_W'(int'(st_idx) * DEPTH + int'(c_tmp))] =
                    st_data[VA_LO +: VA_W];
                s_d.cnt[st_idx] = c_tmp + CNT_W'(1);
            end
        end

        // then the load sees the updated stack
        if (ld_valid && ld_hit) begin
            s_d.rv    = 1'b1;
            s_d.rstk  = ld_idx;
            s_d.rcode = CODE_NONE;
            s_d.rsize = '0;
            s_d.rva   = '0;
            if (ld_in) begin
                s_d.rsize = cfg_size[int'(ld_idx) * SZ_W +: SZ_W];
                if (s_d.cnt[ld_idx] != '0) begin
                    c_tmp = s_d.cnt[ld_idx] - CNT_W'(1);
                    s_d.cnt[ld_idx] = c_tmp;
                    s_d.rcode = CODE_OK;
                    s_d.rva   = s_d.mem[ENT_W'(int'(ld_idx) * DEPTH + int'(c_tmp))];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    bsm_word_fmt u_fmt (
        .code(s_q.rcode), .size(s_q.rsize), .stk(s_q.rstk), .va(s_q.rva),
        .word(resp_data)
    );

    assign resp_valid = s_q.rv;
    assign stk_ovf    = s_q.ovf;

    for (genvar i = 0; i < NUM_STACKS; i++) begin : g_empty
        assign stk_empty[i] = (s_q.cnt[i] == '0);
    end
endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
    parameter int NUM_STACKS = 8,
    parameter int ADDR_W     = 40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic                  ld_valid,
    input logic [ADDR_W-1:0]     ld_addr,
    input logic                  resp_valid,
    input logic [63:0]           resp_data,
    input logic [NUM_STACKS-1:0] stk_empty,
    input logic [NUM_STACKS-1:0] stk_ovf
);
    logic unused_chk;
    assign unused_chk = ^{ld_addr[ADDR_W-1:29], ld_addr[25:8], ld_addr[2:0]};

    // R1
    region_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (resp_valid == $past(ld_valid && ld_addr[28:26] == 3'd6)));

    // R2
    stack_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_addr[28:26] == 3'd6) |=> (resp_data[52:48] == $past(ld_addr[7:3])));

    // R4
    code_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_data[63:62] == 2'd0 || resp_data[63:62] == 2'd3));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !st_valid && ld_addr[28:26] == 3'd6 && int'(ld_addr[7:3]) < NUM_STACKS
         && ((stk_empty >> ld_addr[7:3]) & 1) != 0)
        |=> (resp_data[63:62] == 2'd3 && resp_data[41:7] == '0));

    // R6
    hw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_data[58] && resp_data[57:56] == 2'b00));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stk_ovf & $past(stk_ovf)) == $past(stk_ovf)));
endmodule

bind bufstack_mgr bsm_chk #(.NUM_STACKS(NUM_STACKS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .stk_empty(stk_empty), .stk_ovf(stk_ovf)
);

// File: tb/tb_bufstack_mgr.sv
module tb_bufstack_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int DP = 4;
    localparam int AW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, ld_valid = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [63:0] st_data = '0;
    logic [3*NS-1:0] cfg_size;
    logic resp_valid;
    logic [63:0] resp_data;
    logic [NS-1:0] stk_empty, stk_ovf;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // stack i is configured with size code i (mod 8)
    for (genvar i = 0; i < NS; i++) begin : g_cfg
        assign cfg_size[3*i +: 3] = 3'(i);
    end

    bufstack_mgr #(.NUM_STACKS(NS), .DEPTH(DP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .cfg_size(cfg_size), .resp_valid(resp_valid), .resp_data(resp_data),
        .stk_empty(stk_empty), .stk_ovf(stk_ovf)
    );

    typedef struct packed {
        logic        sv;
        logic [4:0]  ss;
        logic [2:0]  sr;
        logic [34:0] sva;
        logic        lv;
        logic [4:0]  ls;
        logic [2:0]  lr;
        logic        ev;
        logic [1:0]  ec;
        logic [34:0] eva;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd0, 3'd0, 35'd0,     1'b1, 5'd1, 3'd6, 1'b1, 2'd3, 35'd0},     // R5 empty pop
        '{1'b1, 5'd1, 3'd6, 35'h0A1,   1'b0, 5'd0, 3'd0, 1'b0, 2'd0, 35'd0},     // R3 push
        '{1'b1, 5'd1, 3'd6, 35'h7_0000_00A2, 1'b0, 5'd0, 3'd0, 1'b0, 2'd0, 35'd0},
        '{1'b0, 5'd0, 3'd0, 35'd0,     1'b1, 5'd1, 3'd6, 1'b1, 2'd0, 35'h7_0000_00A2}, // R3 R4 LIFO
        '{1'b1, 5'd2, 3'd5, 35'h0B0,   1'b1, 5'd2, 3'd6, 1'b1, 2'd3, 35'd0},     // R1 store ignored
        '{1'b0, 5'd0, 3'd0, 35'd0,     1'b1, 5'd1, 3'd7, 1'b0, 2'd0, 35'd0},     // R1 no response
        '{1'b0, 5'd0, 3'd0, 35'd0,     1'b1, 5'd1, 3'd6, 1'b1, 2'd0, 35'h0A1},   // R3
        '{1'b0, 5'd0, 3'd0, 35'd0,     1'b1, 5'd1, 3'd6, 1'b1, 2'd3, 35'd0},     // R5
        '{1'b1, 5'd3, 3'd6, 35'h0C3,   1'b1, 5'd3, 3'd6, 1'b1, 2'd0, 35'h0C3},   // R9
        '{1'b1, 5'd9, 3'd6, 35'h0D9,   1'b1, 5'd9, 3'd6, 1'b1, 2'd3, 35'd0}      // R11
    };

    function automatic logic [AW-1:0] mk_addr(input logic [4:0] stk, input logic [2:0] rg);
        logic [AW-1:0] a;
        a = '0;
        a[28:26] = rg;
        a[7:3] = stk;
        return a;
    endfunction

    function automatic logic [63:0] exp_word(input logic [1:0] code, input logic [4:0] stk,
                                             input logic [34:0] va);
        logic [2:0] sz;
        sz = (int'(stk) < NS) ? stk[2:0] : 3'd0;
        return {code, sz, 1'b1, 2'b00, 3'b000, stk, 6'd0, va, 7'd0};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle of requests; returns at the following negedge
    task automatic step(input logic sv, input logic [4:0] ss, input logic [2:0] sr,
                        input logic [34:0] sva, input logic lv, input logic [4:0] ls,
                        input logic [2:0] lr);
        st_valid = sv;
        st_addr  = mk_addr(ss, sr);
        st_data  = {22'h3FFFFF, sva, 7'h7F};  // R7 junk outside [41:7]
        ld_valid = lv;
        ld_addr  = mk_addr(ls, lr);
        @(negedge clk);
        st_valid = 1'b0;
        ld_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 resp_valid", 64'(resp_valid), 64'd0);
        chk("R12 stk_empty", 64'(stk_empty), 64'hFF);
        chk("R12 stk_ovf", 64'(stk_ovf), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].sv, VEC[i].ss, VEC[i].sr, VEC[i].sva,
                 VEC[i].lv, VEC[i].ls, VEC[i].lr);
            chk($sformatf("R1/R3 vec %0d valid", i), 64'(resp_valid), 64'(VEC[i].ev));
            if (VEC[i].ev)
                chk($sformatf("R2/R4/R6/R7 vec %0d word", i), resp_data,
                    exp_word(VEC[i].ec, VEC[i].ls, VEC[i].eva));
        end
        chk("R11 empty after table", 64'(stk_empty), 64'hFF);

        // R10 empty flags
        step(1'b1, 5'd2, 3'd6, 35'h4_1234_5678, 1'b0, 5'd0, 3'd0);
        chk("R10 one stack filled", 64'(stk_empty), 64'hFB);
        step(1'b0, 5'd0, 3'd0, 35'd0, 1'b1, 5'd2, 3'd6);
        chk("R7 ignored data bits", resp_data, exp_word(2'd0, 5'd2, 35'h4_1234_5678));
        chk("R10 drained", 64'(stk_empty), 64'hFF);

        // R8 overflow: DEPTH+1 stores, the last one dropped
        for (int k = 0; k <= DP; k++)
            step(1'b1, 5'd5, 3'd6, 35'(100 + k), 1'b0, 5'd0, 3'd0);
        chk("R8 ovf flag", 64'(stk_ovf), 64'h20);
        for (int k = DP - 1; k >= 0; k--) begin
            step(1'b0, 5'd0, 3'd0, 35'd0, 1'b1, 5'd5, 3'd6);
            chk($sformatf("R8 drain %0d", k), resp_data, exp_word(2'd0, 5'd5, 35'(100 + k)));
        end
        step(1'b0, 5'd0, 3'd0, 35'd0, 1'b1, 5'd5, 3'd6);
        chk("R8 dropped value absent", resp_data, exp_word(2'd3, 5'd5, 35'd0));
        chk("R8 flag sticky", 64'(stk_ovf), 64'h20);

        // R9 store and load on a full stack in one cycle
        for (int k = 0; k < DP; k++)
            step(1'b1, 5'd6, 3'd6, 35'(200 + k), 1'b0, 5'd0, 3'd0);
        step(1'b1, 5'd6, 3'd6, 35'd300, 1'b1, 5'd6, 3'd6);
        chk("R9 full same-cycle pop", resp_data, exp_word(2'd0, 5'd6, 35'(200 + DP - 1)));
        chk("R9 full same-cycle ovf", 64'(stk_ovf), 64'h60);
        step(1'b0, 5'd0, 3'd0, 35'd0, 1'b1, 5'd6, 3'd6);
        chk("R9 next top", resp_data, exp_word(2'd0, 5'd6, 35'(200 + DP - 2)));

        // R12 reset clears flags and stacks
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 re-reset ovf", 64'(stk_ovf), 64'd0);
        chk("R12 re-reset empty", 64'(stk_empty), 64'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule